// File: doc/BRIEF.md
# Hashed Page Table Search Engine

This block walks one group of a hashed page table to translate a virtual page. The caller supplies a segment descriptor (virtual segment identifier plus protection key, no-execute and direct-store bits), the 16-bit page index inside the segment, a precomputed hash value, a flag that says whether that hash is the primary or the secondary one, and the table base register. The engine forms the byte address of the eight-entry group, reads the first word of each entry in turn over a word-read memory port, and compares it against the tag built from the segment and page index.

When an entry matches, the engine reads that entry's second word. It then reports a hit with the real page number, the four cache-attribute bits and the derived access rights. If none of the eight entries match, it reports a miss. A segment marked as direct-store is never searched. Reference and change bit updates, caching of translations and fault signalling are left to surrounding logic.

Top module: `hpt_walker`

## Requirements
- R1: The group address is the table origin (base AND 0xFFFF0000) plus the group offset ((hash × 64) AND (((base AND 0x1FF) << 16) OR 0xFFFF)), with 32-bit wraparound. The first read of a search goes to this address.
- R2: For entry slot i, the first word is read at group address + 8·i and the second word at group address + 8·i + 4.
- R3: An entry matches when bit 31 of its first word is set and it equals the expected tag {1, vsid[23:0], secondary flag, page_index[15:10]} under mask 0x7FFFFFBF. Bit 6 (the hash-select bit) takes no part in the compare. An entry with bit 31 clear never matches, even with a correct tag.
- R4: Slots are searched in the order 0 to 7. The first match ends the search, so a hit in slot s costs exactly s+2 word reads, and later matching entries are not reported.
- R5: After eight first-word reads with no match, done is raised with hit=0. Real page, WIMG and rights then read as 0.
- R6: On a hit, real_page returns bits 31:12 of the second word and wimg returns bits 6:3.
- R7: rights = {exec, write, read}. The key is segment bit 29 in user mode and bit 30 in supervisor mode. With the key set, protection code (second-word bits 1:0) 0 gives no read or write, 1 and 3 give read, and 2 gives read and write. With the key clear, codes 0 to 2 give read and write, and code 3 gives read.
- R8: The exec right is set on a hit unless segment bit 28 (no-execute) is set.
- R9: A segment with bit 31 set makes no memory read. Its done pulse comes the cycle after start is taken, with hit=0.
- R10: mem_req stays high with a stable mem_addr until mem_rvalid is seen, for any read latency. mem_req is low while the engine is idle.
- R11: done is a single-cycle pulse that arrives the cycle after the last read is accepted. A start that arrives while busy is ignored.
- R12: After reset the engine is idle, with busy, mem_req, done and hit low and the result outputs zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a search when idle |
| seg_desc | input | 32 | Segment descriptor: bit31 direct-store, 30 supervisor key, 29 user key, 28 no-execute, 23:0 VSID |
| page_index | input | 16 | Page index within the segment |
| hash_val | input | 19 | Hash value selecting the group |
| use_secondary | input | 1 | Hash kind, placed in the expected tag |
| user_mode | input | 1 | 1 selects the user key, 0 the supervisor key |
| table_base | input | 32 | Table origin and size field |
| busy | output | 1 | Search in progress |
| mem_req | output | 1 | Read request |
| mem_addr | output | 32 | Byte address of the requested word |
| mem_rvalid | input | 1 | Read data valid, ends the request |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | One-cycle completion pulse |
| hit | output | 1 | Translation found |
| real_page | output | 20 | Real page number |
| wimg | output | 4 | Cache attribute bits |
| rights | output | 3 | {exec, write, read} |

## Verification
Each read takes effect on the edge where mem_rvalid is sampled, and done follows on the next cycle. The bench's memory model records the cycle of the last data beat it returns, and the bench checks that done is first seen exactly one cycle later. For a direct-store segment it instead checks done one cycle after start. Results are sampled on the falling edge of the cycle in which done is high, and they stay held until the next start. Read counts and the first address are logged by the memory model, so the search order and the early stop are checked at the port.

// File: rtl/hpt_pkg.sv
package hpt_pkg;

    localparam int unsigned ENTRY_BYTES = 8;
    localparam logic [31:0] TAG_MASK    = 32'h7FFF_FFBF;
    localparam logic [31:0] ORG_MASK    = 32'hFFFF_0000;

    localparam int unsigned SEG_DIRECT  = 31;
    localparam int unsigned SEG_KEY_SUP = 30;
    localparam int unsigned SEG_KEY_USR = 29;
    localparam int unsigned SEG_NOEXEC  = 28;

    typedef struct packed {
        logic x;
        logic w;
        logic r;
    } rights_t;

    typedef struct packed {
        logic [19:0] rpn;
        logic [2:0]  rsvd_hi;
        logic        refd;
        logic        chg;
        logic [3:0]  wimg;
        logic        rsvd_lo;
        logic [1:0]  pp;
    } pte_lo_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_TAG,
        ST_DATA,
        ST_DONE
    } walk_state_e;

    function automatic rights_t access_rights(input logic key, input logic [1:0] pp,
                                              input logic nx);
        rights_t res;
        res = '0;
        if (key) begin
            res.r = (pp != 2'd0);
            res.w = (pp == 2'd2);
        end else begin
            res.r = 1'b1;
            res.w = (pp != 2'd3);
        end
        res.x = ~nx;
        return res;
    endfunction

endpackage

// File: rtl/hpt_addr_gen.sv
module hpt_addr_gen
    import hpt_pkg::*;
#(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned HASH_W  = 19,
    parameter int unsigned ENTRIES = 8
) (
    input  logic [ADDR_W-1:0]          table_base,
    input  logic [HASH_W-1:0]          hash_val,
    input  logic [$clog2(ENTRIES)-1:0] slot,
    input  logic                       second_word,
    output logic [ADDR_W-1:0]          word_addr
);
    localparam int unsigned GRP_SHIFT = $clog2(ENTRIES * ENTRY_BYTES);

    logic [ADDR_W-1:0] origin;
    logic [ADDR_W-1:0] size_mask;
    logic [ADDR_W-1:0] hash_scaled;
    logic [ADDR_W-1:0] entry_off;

    always_comb begin
        origin      = table_base & ORG_MASK;
        size_mask   = ADDR_W'({table_base[8:0], 16'hFFFF});
        hash_scaled = ADDR_W'({hash_val, {GRP_SHIFT{1'b0}}});
        entry_off   = ADDR_W'({slot, second_word, 2'b00});
        word_addr   = origin + (hash_scaled & size_mask) + entry_off;
    end
endmodule

// File: rtl/hpt_tag_cmp.sv
module hpt_tag_cmp
    import hpt_pkg::*;
#(
    parameter int unsigned VSID_W = 24,
    parameter int unsigned API_W  = 6
) (
    input  logic [VSID_W-1:0] vsid,
    input  logic [API_W-1:0]  api,
    input  logic              secondary,
    input  logic [31:0]       word0,
    output logic              match
);
    logic [31:0] expected;

    always_comb begin
        expected = {1'b1, vsid, secondary, api};
        match    = word0[31] && (((word0 ^ expected) & TAG_MASK) == 32'd0);
    end
endmodule

// File: rtl/hpt_rights.sv
module hpt_rights
    import hpt_pkg::*;
(
    input  logic [31:0] seg,
    input  logic        user_mode,
    input  logic [1:0]  pp,
    output rights_t     rights
);
    logic key;

    always_comb begin
        key    = user_mode ? seg[SEG_KEY_USR] : seg[SEG_KEY_SUP];
        rights = access_rights(key, pp, seg[SEG_NOEXEC]);
    end
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
    import hpt_pkg::*;
#(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned HASH_W  = 19,
    parameter int unsigned PIDX_W  = 16,
    parameter int unsigned VSID_W  = 24,
    parameter int unsigned API_W   = 6,
    parameter int unsigned ENTRIES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [31:0]       seg_desc,
    input  logic [PIDX_W-1:0] page_index,
    input  logic [HASH_W-1:0] hash_val,
    input  logic              use_secondary,
    input  logic              user_mode,
    input  logic [ADDR_W-1:0] table_base,
    output logic              busy,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    output logic              done,
    output logic              hit,
    output logic [ADDR_W-13:0] real_page,
    output logic [3:0]        wimg,
    output logic [2:0]        rights
);
    localparam int unsigned SLOT_W = $clog2(ENTRIES);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(ENTRIES - 1);

    walk_state_e         state;
    logic [31:0]         seg_q;
    logic [PIDX_W-1:0]   pidx_q;
    logic [HASH_W-1:0]   hash_q;
    logic                sec_q;
    logic                user_q;
    logic [ADDR_W-1:0]   base_q;
    logic [SLOT_W-1:0]   slot_q;
    logic                hit_q;
    logic [ADDR_W-13:0]  rpn_q;
    logic [3:0]          wimg_q;
    rights_t             rights_q;

    logic                tag_match;
    rights_t             beat_rights;
    pte_lo_t             lo_word;

    assign lo_word = pte_lo_t'(mem_rdata);

    hpt_addr_gen #(
        .ADDR_W (ADDR_W),
        .HASH_W (HASH_W),
        .ENTRIES(ENTRIES)
    ) u_addr (
        .table_base (base_q),
        .hash_val   (hash_q),
        .slot       (slot_q),
        .second_word(state == ST_DATA),
        .word_addr  (mem_addr)
    );

    hpt_tag_cmp #(
        .VSID_W(VSID_W),
        .API_W (API_W)
    ) u_tag (
        .vsid     (seg_q[VSID_W-1:0]),
        .api      (pidx_q[PIDX_W-1 -: API_W]),
        .secondary(sec_q),
        .word0    (mem_rdata),
        .match    (tag_match)
    );

    hpt_rights u_rights (
        .seg      (seg_q),
        .user_mode(user_q),
        .pp       (lo_word.pp),
        .rights   (beat_rights)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            seg_q    <= '0;
            pidx_q   <= '0;
            hash_q   <= '0;
            sec_q    <= 1'b0;
            user_q   <= 1'b0;
            base_q   <= '0;
            slot_q   <= '0;
            hit_q    <= 1'b0;
            rpn_q    <= '0;
            wimg_q   <= '0;
            rights_q <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        seg_q    <= seg_desc;
                        pidx_q   <= page_index;
                        hash_q   <= hash_val;
                        sec_q    <= use_secondary;
                        user_q   <= user_mode;
                        base_q   <= table_base;
                        slot_q   <= '0;
                        hit_q    <= 1'b0;
                        rpn_q    <= '0;
                        wimg_q   <= '0;
                        rights_q <= '0;
                        state    <= seg_desc[SEG_DIRECT] ? ST_DONE : ST_TAG;
                    end
                end
                ST_TAG: begin
                    if (mem_rvalid) begin
                        if (tag_match) begin
                            state <= ST_DATA;
                        end else if (slot_q == LAST_SLOT) begin
                            state <= ST_DONE;
                        end else begin
                            slot_q <= slot_q + 1'b1;
                        end
                    end
                end
                ST_DATA: begin
                    if (mem_rvalid) begin
                        rpn_q    <= lo_word.rpn;
                        wimg_q   <= lo_word.wimg;
                        rights_q <= beat_rights;
                        hit_q    <= 1'b1;
                        state    <= ST_DONE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy      = (state != ST_IDLE);
        mem_req   = (state == ST_TAG) || (state == ST_DATA);
        done      = (state == ST_DONE);
        hit       = hit_q;
        real_page = rpn_q;
        wimg      = wimg_q;
        rights    = rights_q;
    end
endmodule

// File: rtl/hpt_walker_chk.sv
module hpt_walker_chk #(
    parameter int unsigned ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [31:0]       seg_desc,
    input logic              busy,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rvalid,
    input logic              done,
    input logic              hit,
    input logic [2:0]        rights
);
    p_req_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req);

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_busy_until_done_r11: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);

    p_miss_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (done && !hit) |-> (rights == 3'b000));

    p_direct_seg_r9: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && seg_desc[31]) |=> (done && !hit));

    p_write_implies_read_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> !(rights[1] && !rights[0]));
endmodule

bind hpt_walker hpt_walker_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .seg_desc  (seg_desc),
    .busy      (busy),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_rvalid(mem_rvalid),
    .done      (done),
    .hit       (hit),
    .rights    (rights)
);

// File: tb/hpt_walker_bench.sv
module hpt_walker_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] seg_desc = '0;
    logic [15:0] page_index = '0;
    logic [18:0] hash_val = '0;
    logic        use_secondary = 1'b0;
    logic        user_mode = 1'b0;
    logic [31:0] table_base = '0;
    logic        busy;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        done;
    logic        hit;
    logic [19:0] real_page;
    logic [3:0]  wimg;
    logic [2:0]  rights;

    always #10 clk = ~clk;

    hpt_walker u_hpt_walker (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .seg_desc     (seg_desc),
        .page_index   (page_index),
        .hash_val     (hash_val),
        .use_secondary(use_secondary),
        .user_mode    (user_mode),
        .table_base   (table_base),
        .busy         (busy),
        .mem_req      (mem_req),
        .mem_addr     (mem_addr),
        .mem_rvalid   (mem_rvalid),
        .mem_rdata    (mem_rdata),
        .done         (done),
        .hit          (hit),
        .real_page    (real_page),
        .wimg         (wimg),
        .rights       (rights)
    );

    typedef struct packed {
        logic [31:0] seg;
        logic [15:0] pidx;
        logic [18:0] hash;
        logic        sec;
        logic        user;
        logic [31:0] base;
        logic [3:0]  slot;
        logic [1:0]  pp;
        logic        flip;
        logic [2:0]  lat;
        logic        exp_hit;
        logic [2:0]  exp_rights;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{32'h0000_1234, 16'hFC00, 19'h00001, 1'b0, 1'b0, 32'h0010_0000, 4'd0, 2'd0, 1'b0, 3'd0, 1'b1, 3'b111},
        '{32'h4012_3456, 16'h1400, 19'h00123, 1'b1, 1'b0, 32'h0012_0003, 4'd3, 2'd0, 1'b0, 3'd1, 1'b1, 3'b100},
        '{32'h2000_0055, 16'h0400, 19'h01FFF, 1'b0, 1'b1, 32'h0012_0003, 4'd7, 2'd2, 1'b0, 3'd0, 1'b1, 3'b111},
        '{32'h3000_0077, 16'h8000, 19'h00ABC, 1'b1, 1'b1, 32'h0040_0001, 4'd5, 2'd1, 1'b1, 3'd2, 1'b1, 3'b001},
        '{32'h5000_0010, 16'hFFFF, 19'h7FFFF, 1'b0, 1'b0, 32'hFFFF_01FF, 4'd2, 2'd3, 1'b0, 3'd0, 1'b1, 3'b001},
        '{32'h2000_0099, 16'h0000, 19'h00010, 1'b0, 1'b0, 32'h1234_5600, 4'd1, 2'd3, 1'b0, 3'd3, 1'b1, 3'b101},
        '{32'h0000_00AA, 16'h2C00, 19'h00200, 1'b0, 1'b1, 32'h0008_0007, 4'd8, 2'd2, 1'b0, 3'd0, 1'b0, 3'b000},
        '{32'h6000_0ABC, 16'h7C00, 19'h03333, 1'b1, 1'b1, 32'h00A0_000F, 4'd6, 2'd3, 1'b0, 3'd4, 1'b1, 3'b101}
    };

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    logic [31:0] tbl [16];
    logic [31:0] grp_addr = '0;
    int          lat_cfg = 0;
    int          lat_cnt = 0;
    int          rd_count = 0;
    logic [31:0] first_addr = '0;
    int          last_rv_cyc = 0;
    logic        hold_err = 1'b0;
    logic [31:0] wait_addr = '0;
    logic        waiting = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // memory model: responds on the falling edge after lat_cfg idle cycles
    always @(negedge clk) begin
        if (!mem_req) begin
            mem_rvalid = 1'b0;
            lat_cnt    = 0;
            waiting    = 1'b0;
        end else if (mem_rvalid) begin
            mem_rvalid = 1'b0;
            lat_cnt    = 0;
            waiting    = 1'b0;
        end else begin
            if (waiting && (mem_addr != wait_addr)) hold_err = 1'b1;
            waiting   = 1'b1;
            wait_addr = mem_addr;
            if (lat_cnt >= lat_cfg) begin
                if (rd_count == 0) first_addr = mem_addr;
                if ((mem_addr - grp_addr) < 32'd64)
                    mem_rdata = tbl[(mem_addr - grp_addr) >> 2];
                else
                    mem_rdata = 32'h0;
                mem_rvalid  = 1'b1;
                rd_count    = rd_count + 1;
                last_rv_cyc = cyc;
            end else begin
                lat_cnt = lat_cnt + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] group_of(input logic [31:0] base, input logic [18:0] h);
        logic [31:0] msk;
        msk = {7'd0, base[8:0], 16'hFFFF};
        return (base & 32'hFFFF_0000) + (({13'd0, h} << 6) & msk);
    endfunction

    task automatic fill_table(input int vi, input vec_t v);
        logic [31:0] tag;
        tag = {1'b1, v.seg[23:0], v.sec, v.pidx[15:10]};
        for (int j = 0; j < 8; j++) begin
            if (j < int'(v.slot)) begin
                if (j % 2 == 0) tbl[2*j] = tag & 32'h7FFF_FFFF;
                else            tbl[2*j] = tag ^ 32'h0000_0080;
            end else if (j == int'(v.slot)) begin
                tbl[2*j] = v.flip ? (tag ^ 32'h0000_0040) : tag;
            end else begin
                tbl[2*j] = tag;
            end
            tbl[2*j+1] = {12'hA5C, 4'(vi), 4'(j), 3'b000, 1'b1, 1'b0, 4'(j + 3), 1'b0, v.pp};
        end
    endtask

    task automatic wait_done(output int dcyc, output bit ok);
        ok = 1'b0;
        dcyc = 0;
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            if (done) begin
                ok = 1'b1;
                dcyc = cyc;
                break;
            end
        end
    endtask

    task automatic run_vec(input int vi, input bit poke_busy);
        vec_t v;
        int   dcyc;
        bit   ok;
        int   exp_reads;
        v = VECS[vi];
        fill_table(vi, v);
        @(negedge clk);
        grp_addr   = group_of(v.base, v.hash);
        lat_cfg    = int'(v.lat);
        rd_count   = 0;
        hold_err   = 1'b0;
        seg_desc   = v.seg;
        page_index = v.pidx;
        hash_val   = v.hash;
        use_secondary = v.sec;
        user_mode  = v.user;
        table_base = v.base;
        start      = 1'b1;
        @(negedge clk);
        start      = 1'b0;
        if (poke_busy) begin
            repeat (3) @(negedge clk);
            seg_desc = 32'h8000_0000;
            start    = 1'b1;
            @(negedge clk);
            start    = 1'b0;
        end
        wait_done(dcyc, ok);
        chk(ok, "R11 done seen", 32'(ok), 32'd1);
        chk(hit == v.exp_hit, "R3 R5 hit", 32'(hit), 32'(v.exp_hit));
        chk(rights == v.exp_rights, "R7 R8 rights", 32'(rights), 32'(v.exp_rights));
        chk(first_addr == grp_addr, "R1 group address", first_addr, grp_addr);
        exp_reads = v.exp_hit ? int'(v.slot) + 2 : 8;
        chk(rd_count == exp_reads, "R4 R2 read count", 32'(rd_count), 32'(exp_reads));
        chk(dcyc == last_rv_cyc + 1, "R11 done timing", 32'(dcyc), 32'(last_rv_cyc + 1));
        chk(!hold_err, "R10 request hold", 32'(hold_err), 32'd0);
        if (v.exp_hit) begin
            chk(real_page == {12'hA5C, 4'(vi), v.slot}, "R6 real page",
                32'(real_page), 32'({12'hA5C, 4'(vi), v.slot}));
            chk(wimg == 4'(v.slot + 4'd3), "R6 wimg", 32'(wimg), 32'(v.slot + 4'd3));
        end else begin
            chk(real_page == 20'd0 && wimg == 4'd0, "R5 miss outputs",
                {real_page, 8'd0, wimg}, 32'd0);
        end
        @(negedge clk);
        chk(!done, "R11 done one cycle", 32'(done), 32'd0);
        chk(!busy, "R11 idle after done", 32'(busy), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int dcyc;
        int scyc;
        bit ok;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk(!busy && !mem_req && !done && !hit, "R12 reset flags",
            {28'd0, busy, mem_req, done, hit}, 32'd0);
        chk(real_page == 20'd0 && wimg == 4'd0 && rights == 3'd0, "R12 reset outputs",
            {real_page, 1'b0, wimg, rights, 4'd0}, 32'd0);

        for (int i = 0; i < NVEC; i++) run_vec(i, 1'b0);

        // R11 start during a search is ignored (would otherwise end as a miss)
        run_vec(7, 1'b1);

        // R9 direct-store segment: no reads, done next cycle, miss
        @(negedge clk);
        rd_count   = 0;
        seg_desc   = 32'hC000_1234;
        table_base = 32'h0010_0000;
        start      = 1'b1;
        scyc       = cyc;
        @(negedge clk);
        start      = 1'b0;
        chk(done, "R9 done after start", 32'(done), 32'd1);
        dcyc = cyc;
        chk(dcyc == scyc + 1, "R9 done cycle", 32'(dcyc), 32'(scyc + 1));
        chk(!hit && rights == 3'd0, "R9 miss", {28'd0, hit, rights}, 32'd0);
        chk(rd_count == 0, "R9 no reads", 32'(rd_count), 32'd0);
        wait_done(dcyc, ok);
        chk(!ok, "R11 no second done", 32'(ok), 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule